// File: doc/BRIEF.md
# Programmable Delay Circular Buffer

This block delays a 10-bit sample stream by a run-time programmable number of clock edges. A length word between 0 and 1279 is loaded under a strobe. The delay N is that word plus two, so N can be set from 2 to 1281 cycles. In pass-through mode the block takes a new sample on every enabled edge and presents it N edges later. In recirculate mode it ignores the data input and keeps rotating the last N stored samples, so the output repeats with period N.

An active-low clock enable freezes all state. It passes through one register stage first, so it acts one edge after it is sampled. An active-low output enable only gates what the output port shows. A compile-time parameter picks whether all internal events happen on the rising or the falling clock edge.

Storage is a power-of-two ring of samples addressed by a write pointer. The read address trails the write pointer by N. Because of this, a new length takes effect on the next edge without clearing stored data.

Top module: `prog_delay_ring`

## Requirements
- R1: While rst_ni is low and after it is released, the length is N=2, the write position is zero, the clock-enable stage is off, and the output register holds 0, so data_o reads 0 with oe_ni low.
- R2: With mode_i low, a sample presented on data_i at an enabled edge appears on data_o at the N-th enabled edge after it, where N = loaded length word + 2.
- R3: The length word is taken from lc_i only at an enabled edge where lcen_i is high. At every other edge the stored length is kept.
- R4: A length word above 1279 is saturated to 1279, giving N=1281.
- R5: With mode_i high, data_i has no effect. The value shown on data_o at each enabled edge equals the value shown N enabled edges earlier.
- R6: While the internal enable is off, data_o, the length and the ring position all hold their values, whatever data_i, lcen_i, lc_i or mode_i do.
- R7: cken_ni is active low and is registered before use. A level sampled at edge k governs edge k+1 onward, and the edge that samples it still follows the previous level.
- R8: With oe_ni high, data_o reads 0 and valid_o reads 0. With oe_ni low, valid_o reads 1 and data_o shows the output register. oe_ni never changes internal shifting or loading.
- R9: mode_i is sampled at each enabled edge, so the mode can be switched between any two edges with no lost or repeated position.
- R10: A length loaded at edge k sets the delay from edge k+1 on. Stored samples are kept, so the delay to any sample written earlier is measured from the edge it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; active edge chosen by parameter RISE_EDGE |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cken_ni | input | 1 | Clock enable, active low, acts one edge late |
| mode_i | input | 1 | 0 = pass-through delay, 1 = recirculate |
| lcen_i | input | 1 | Length load strobe |
| lc_i | input | 11 | Length word; delay N = value + 2, saturated at 1279 |
| data_i | input | 10 | Input sample |
| oe_ni | input | 1 | Output enable, active low |
| data_o | output | 10 | Delayed sample, 0 when output disabled |
| valid_o | output | 1 | High when the output is enabled |

## Verification
The assertions assume that every control and data input is settled around the active edge, and that reset is released only while the clock runs. The bench drives all inputs on the inactive edge and samples half a period later. The pointer and length checks also assume that the enable register is the only gate on state. For this reason, the bench toggles cken_ni while it also drives lcen_i and changes data, to show that nothing leaks through. Outputs read from ring slots never written since reset are not checked.

// File: rtl/prog_delay_ring_pkg.sv
package prog_delay_ring_pkg;
  localparam int DATA_W  = 10;
  localparam int LC_W    = 11;
  localparam int MAX_LC  = 1279;
  localparam int LEN_OFS = 2;
endpackage

// File: rtl/prog_delay_ring_clk.sv
module prog_delay_ring_clk #(
  parameter bit RISE_EDGE = 1'b1
) (
  input  logic clk_i,
  output logic clk_o
);
  generate
    if (RISE_EDGE) begin : g_rise
      assign clk_o = clk_i;
    end else begin : g_fall
      assign clk_o = ~clk_i;
    end
  endgenerate
endmodule

// File: rtl/prog_delay_ring_ctrl.sv
module prog_delay_ring_ctrl #(
  parameter int LC_W    = prog_delay_ring_pkg::LC_W,
  parameter int MAX_LC  = prog_delay_ring_pkg::MAX_LC,
  parameter int LEN_OFS = prog_delay_ring_pkg::LEN_OFS,
  parameter int ADDR_W  = $clog2(MAX_LC + LEN_OFS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cken_ni,
  input  logic              lcen_i,
  input  logic [LC_W-1:0]   lc_i,
  output logic              en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  localparam int NW = (LC_W > ADDR_W ? LC_W : ADDR_W) + 1;

  logic              en_q;
  logic [LC_W-1:0]   len_q;
  logic [LC_W-1:0]   len_d;
  logic [ADDR_W-1:0] wp_q;
  logic [NW-1:0]     n_len;

  // saturate out-of-range words
  assign len_d = (lc_i > LC_W'(MAX_LC)) ? LC_W'(MAX_LC) : lc_i;

  // one register stage on the enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= ~cken_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      wp_q  <= '0;
    end else if (en_q) begin
      wp_q <= wp_q + 1'b1;
      if (lcen_i) len_q <= len_d;
    end
  end

  assign n_len     = NW'(len_q) + NW'(LEN_OFS);
  assign en_o      = en_q;
  assign wr_addr_o = wp_q;
  assign rd_addr_o = wp_q - ADDR_W'(n_len);

  a_r3_len_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_q && lcen_i) |=> $stable(len_q));
  a_r4_len_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= LC_W'(MAX_LC));
  a_r6_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> $stable(wp_q));
  a_r2_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> wp_q == $past(wp_q) + 1'b1);
  a_r7_en_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cken_ni) |=> en_q);
endmodule

// File: rtl/prog_delay_ring_ram.sv
module prog_delay_ring_ram #(
  parameter int DATA_W = prog_delay_ring_pkg::DATA_W,
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/prog_delay_ring.sv
module prog_delay_ring #(
  parameter int DATA_W    = prog_delay_ring_pkg::DATA_W,
  parameter int LC_W      = prog_delay_ring_pkg::LC_W,
  parameter int MAX_LC    = prog_delay_ring_pkg::MAX_LC,
  parameter bit RISE_EDGE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cken_ni,
  input  logic              mode_i,
  input  logic              lcen_i,
  input  logic [LC_W-1:0]   lc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int LEN_OFS = prog_delay_ring_pkg::LEN_OFS;
  localparam int ADDR_W  = $clog2(MAX_LC + LEN_OFS + 1);

  logic              clk_int;
  logic              en;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] dout_q;

  prog_delay_ring_clk #(.RISE_EDGE(RISE_EDGE)) u_clk (
    .clk_i (clk_i),
    .clk_o (clk_int)
  );

  prog_delay_ring_ctrl #(
    .LC_W(LC_W), .MAX_LC(MAX_LC), .LEN_OFS(LEN_OFS), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk_i     (clk_int),
    .rst_ni    (rst_ni),
    .cken_ni   (cken_ni),
    .lcen_i    (lcen_i),
    .lc_i      (lc_i),
    .en_o      (en),
    .wr_addr_o (wr_addr),
    .rd_addr_o (rd_addr)
  );

  // recirculate writes back the slot being read out
  assign wr_data = mode_i ? rd_data : data_i;

  prog_delay_ring_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i     (clk_int),
    .we_i      (en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  always_ff @(posedge clk_int or negedge rst_ni) begin
    if (!rst_ni)  dout_q <= '0;
    else if (en)  dout_q <= rd_data;
  end

  assign valid_o = ~oe_ni;
  assign data_o  = oe_ni ? '0 : dout_q;

  a_r6_out_hold: assert property (@(posedge clk_int) disable iff (!rst_ni)
    !en |=> $stable(dout_q));
  a_r5_recirc_wb: assert property (@(posedge clk_int) disable iff (!rst_ni)
    (en && mode_i) |=> dout_q == $past(rd_data));
endmodule

// File: tb/sim_prog_delay_ring.sv
module sim_prog_delay_ring;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cken_n = 1'b1;
  logic       mode = 1'b0;
  logic       lcen = 1'b0;
  logic [10:0] lc = '0;
  logic [9:0] din = '0;
  logic       oe_n = 1'b0;
  logic [9:0] dout;
  logic       vld;

  int errors = 0;
  int checks = 0;

  // model state, indexed by enabled edge count
  logic [9:0] hist [8192];
  bit         hist_v [8192];
  int         t = 0;
  int         n_m = 2;
  bit         en_m = 1'b0;
  logic [9:0] exp_out = '0;
  bit         exp_v = 1'b1;

  always #2 clk = ~clk;

  prog_delay_ring u0 (
    .clk_i(clk), .rst_ni(rst_n), .cken_ni(cken_n), .mode_i(mode),
    .lcen_i(lcen), .lc_i(lc), .data_i(din), .oe_ni(oe_n),
    .data_o(dout), .valid_o(vld)
  );

  // {lc, mode, cycles}
  localparam int NV = 7;
  localparam int VLC  [NV] = '{0, 5, 5, 1, 3, 10, 0};
  localparam int VMOD [NV] = '{0, 0, 1, 0, 1, 0, 1};
  localparam int VCYC [NV] = '{20, 30, 25, 30, 20, 40, 12};

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic [9:0] d, input logic m, input logic le,
                      input logic [10:0] l, input logic ck, input logic oe,
                      input string tag);
    @(negedge clk);
    din = d; mode = m; lcen = le; lc = l; cken_n = ck; oe_n = oe;
    @(posedge clk);
    if (en_m) begin
      if (t >= n_m) begin exp_out = hist[t-n_m]; exp_v = hist_v[t-n_m]; end
      else exp_v = 1'b0;
      hist[t]   = m ? exp_out : d;
      hist_v[t] = m ? exp_v : 1'b1;
      t++;
      if (le) n_m = ((l > 11'd1279) ? 1279 : int'(l)) + 2;
    end
    en_m = !ck;
    #1;
    if (oe) begin
      check({tag, "/R8 data"}, dout, 10'd0);
      check({tag, "/R8 valid"}, {9'd0, vld}, 10'd0);
    end else if (exp_v) begin
      check(tag, dout, exp_out);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [9:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset data", dout, 10'd0);
    check("R8 valid", {9'd0, vld}, 10'd1);
    rst_n = 1'b1;
    // first edge only arms the enable stage (R7)
    tick(10'h3, 1'b0, 1'b0, 11'd0, 1'b0, 1'b0, "R7 arm");
    check("R1 after release", dout, 10'd0);

    for (int k = 0; k < NV; k++) begin
      tick(10'(k * 91 + 7), VMOD[k][0], 1'b1, 11'(VLC[k]), 1'b0, 1'b0,
           VMOD[k] != 0 ? "R9 switch" : "R10 reload");
      for (int c = 0; c < VCYC[k]; c++)
        tick(10'(c * 37 + k * 13 + 1), VMOD[k][0], 1'b0, 11'd0, 1'b0, 1'b0,
             VMOD[k] != 0 ? "R5" : "R2");
    end

    // R3: word without strobe keeps current length
    tick(10'h1, 1'b0, 1'b1, 11'd2, 1'b0, 1'b0, "R3 load");
    for (int c = 0; c < 12; c++)
      tick(10'(c * 5 + 100), 1'b0, 1'b0, 11'd30, 1'b0, 1'b0, "R3");

    // R7/R6: disable, one more edge still moves, then hold
    tick(10'h155, 1'b0, 1'b0, 11'd0, 1'b1, 1'b0, "R7 late");
    held = dout;
    for (int c = 0; c < 6; c++) begin
      tick(10'(c * 77 + 3), c[0], 1'b1, 11'd9, 1'b1, 1'b0, "R6");
      check("R6 hold", dout, held);
    end
    tick(10'h2aa, 1'b0, 1'b0, 11'd0, 1'b0, 1'b0, "R7 rearm");
    check("R7 still held", dout, held);
    for (int c = 0; c < 8; c++)
      tick(10'(c * 3 + 400), 1'b0, 1'b0, 11'd0, 1'b0, 1'b0, "R6 resume");

    // R8: output gated, internals keep running
    for (int c = 0; c < 6; c++)
      tick(10'(c + 600), 1'b0, 1'b0, 11'd0, 1'b0, 1'b1, "R8 off");
    for (int c = 0; c < 8; c++)
      tick(10'(c + 700), 1'b0, 1'b0, 11'd0, 1'b0, 1'b0, "R8 on");

    // R4: oversize word saturates to N=1281
    tick(10'h5, 1'b0, 1'b1, 11'd2047, 1'b0, 1'b0, "R4 load");
    for (int c = 0; c < 1290; c++)
      tick(10'(c * 11 + 9), 1'b0, 1'b0, 11'd0, 1'b0, 1'b0, "R4");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule